// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block sequences a non-pipelined 32-bit load/store processor. The processor runs each instruction as a chain of one-cycle steps over a shared datapath. The block holds a 4-bit state register. From that state, the opcode, the two destination-register fields of the current instruction and the datapath's equality flag, it drives every enable and select of the datapath: the program counter write strobes, the instruction register load, the memory write, the register file write, the memory address select, the two ALU operand selects, the ALU operation, the destination select, the write-back source and the immediate extension type.

Five instruction classes are handled, and each follows its own state path of fixed length. Every path starts with the same fetch and decode steps. The decode step also uses the ALU, which is idle at that point, to form the branch target ahead of time. As a result, a branch only needs one further step, in which it compares the operands and conditionally loads the program counter. An opcode outside the five classes ends the instruction after decode and changes no architectural state.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While rst_ni is low the state is the fetch code 0000 and the outputs carry the fetch step's controls.
- R2: In the fetch state (0000): ir_wr_o=1, pc_wr_o=1, pc_en_o=1, addr_sel_o=0 (address from PC), alu_a_sel_o=0 (PC), alu_b_sel_o=01 (constant 4), alu_op_o=00 (add). No other write is asserted. The next state is always decode (0001).
- R3: In the decode state (0001) no write strobe is asserted. The ALU forms the branch target with alu_a_sel_o=0, alu_b_sel_o=11 (sign-extended offset shifted by two), alu_op_o=00 and ext_zero_o=0.
- R4: Decode dispatches on opcode_i. Opcode 0x00 (R-type) goes to 0100, 0x0D (OR-immediate) to 0110, 0x23 (load) to 1000, 0x2B (store) to 1011, and 0x04 (branch-if-equal) to 0010.
- R5: The branch state (0010) sets pc_wr_cond_o=1, pc_src_o=1 (target register), alu_a_sel_o=1, alu_b_sel_o=00 and alu_op_o=01 (subtract). pc_en_o equals zero_i in this state. The next state is fetch, so a branch takes 3 cycles.
- R6: An R-type instruction passes through 0100 (alu_a_sel_o=1, alu_b_sel_o=00, alu_op_o=10, function-coded) and then 0101. In 0101 it writes register rd with reg_dst_o=1 and mem_to_reg_o=0. It takes 4 cycles.
- R7: An OR-immediate instruction passes through 0110 (alu_a_sel_o=1, alu_b_sel_o=10, alu_op_o=11, ext_zero_o=1) and then 0111. In 0111 it writes rt with reg_dst_o=0. It takes 4 cycles. ext_zero_o is 1 in no other state.
- R8: A load passes through 1000 (address: alu_a_sel_o=1, alu_b_sel_o=10, alu_op_o=00, sign extension), then 1001 (addr_sel_o=1, memory read), then 1010. In 1010 it writes rt with mem_to_reg_o=1. It takes 5 cycles.
- R9: A store passes through 1011 (same address controls as a load) and then 1100, where addr_sel_o=1 and mem_wr_o=1. It takes 4 cycles and never writes a register.
- R10: state_o reports the 4-bit state code, using exactly the codes listed in R2 to R9.
- R11: Any other opcode returns from decode directly to fetch, with no write strobe asserted in either cycle.
- R12: reg_wr_o stays low in a write-back state whose selected destination index (rd_idx_i when reg_dst_o=1, else rt_idx_i) is zero.
- R13: At most one of ir_wr_o, mem_wr_o and reg_wr_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field of the instruction register |
| rt_idx_i | input | 5 | rt register index of the instruction |
| rd_idx_i | input | 5 | rd register index of the instruction |
| zero_i | input | 1 | Datapath equality flag (A equals B) |
| state_o | output | 4 | Current state code |
| pc_wr_o | output | 1 | Unconditional PC write request |
| pc_wr_cond_o | output | 1 | PC write request qualified by zero_i |
| pc_en_o | output | 1 | Effective PC load enable |
| pc_src_o | output | 1 | PC source: 0 ALU result, 1 ALU output register |
| ir_wr_o | output | 1 | Instruction register load |
| mem_wr_o | output | 1 | Memory write strobe |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALU output register |
| reg_wr_o | output | 1 | Register file write strobe |
| reg_dst_o | output | 1 | Destination: 0 rt, 1 rd |
| mem_to_reg_o | output | 1 | Write-back source: 0 ALU output, 1 memory data register |
| alu_a_sel_o | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel_o | output | 2 | ALU B operand: 00 B, 01 four, 10 immediate, 11 immediate shifted by two |
| alu_op_o | output | 2 | ALU operation: 00 add, 01 subtract, 10 by function code, 11 OR |
| ext_zero_o | output | 1 | Immediate extension: 0 sign, 1 zero |

## Verification
All control outputs are combinational in the registered state and the current inputs. They are therefore due in the same cycle that the state is entered, and each state lasts exactly one clock. The bench drives the inputs on the falling edge and compares state and outputs one time unit later, before the next rising edge. It then advances exactly one rising edge for each step of the expected path. The expected path and its length are derived separately for each opcode, so a late or early transition shows up as a state mismatch at that step. The sweep covers all 64 opcodes with both flag values and four destination-index pairs, including zero indices.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int OPC_W   = 6;
  localparam int ST_W    = 4;
  localparam int BSEL_W  = 2;
  localparam int AOP_W   = 2;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_LW    = 6'h23;
  localparam logic [OPC_W-1:0] OPC_SW    = 6'h2B;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH   = 4'b0000,
    ST_DECODE  = 4'b0001,
    ST_BR_EXE  = 4'b0010,
    ST_R_EXE   = 4'b0100,
    ST_R_WB    = 4'b0101,
    ST_ORI_EXE = 4'b0110,
    ST_ORI_WB  = 4'b0111,
    ST_LW_ADDR = 4'b1000,
    ST_LW_MEM  = 4'b1001,
    ST_LW_WB   = 4'b1010,
    ST_SW_ADDR = 4'b1011,
    ST_SW_MEM  = 4'b1100
  } state_e;

  typedef enum logic [2:0] {
    CL_NONE, CL_RTYPE, CL_ORI, CL_LOAD, CL_STORE, CL_BRANCH
  } iclass_e;

  localparam logic [BSEL_W-1:0] BSEL_REGB   = 2'b00;
  localparam logic [BSEL_W-1:0] BSEL_FOUR   = 2'b01;
  localparam logic [BSEL_W-1:0] BSEL_IMM    = 2'b10;
  localparam logic [BSEL_W-1:0] BSEL_IMM_SH = 2'b11;

  localparam logic [AOP_W-1:0] AOP_ADD  = 2'b00;
  localparam logic [AOP_W-1:0] AOP_SUB  = 2'b01;
  localparam logic [AOP_W-1:0] AOP_FUNC = 2'b10;
  localparam logic [AOP_W-1:0] AOP_OR   = 2'b11;

  typedef struct packed {
    logic              pc_wr;
    logic              pc_wr_cond;
    logic              pc_src;
    logic              ir_wr;
    logic              mem_wr;
    logic              addr_sel;
    logic              reg_wr_req;
    logic              reg_dst;
    logic              mem_to_reg;
    logic              alu_a_sel;
    logic [BSEL_W-1:0] alu_b_sel;
    logic [AOP_W-1:0]  alu_op;
    logic              ext_zero;
  } ctrl_t;
endpackage

// File: rtl/mc_opc_decode.sv
module mc_opc_decode
  import mc_ctrl_pkg::*;
#(
  parameter int OW = OPC_W
) (
  input  logic [OW-1:0] opcode_i,
  output iclass_e       class_o
);
  always_comb begin
    unique case (opcode_i)
      OPC_RTYPE: class_o = CL_RTYPE;
      OPC_ORI:   class_o = CL_ORI;
      OPC_LW:    class_o = CL_LOAD;
      OPC_SW:    class_o = CL_STORE;
      OPC_BEQ:   class_o = CL_BRANCH;
      default:   class_o = CL_NONE;
    endcase
  end
endmodule

// File: rtl/mc_seq.sv
module mc_seq
  import mc_ctrl_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  iclass_e class_i,
  output state_e  state_o
);
  state_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (class_i)
          CL_RTYPE:  state_d = ST_R_EXE;
          CL_ORI:    state_d = ST_ORI_EXE;
          CL_LOAD:   state_d = ST_LW_ADDR;
          CL_STORE:  state_d = ST_SW_ADDR;
          CL_BRANCH: state_d = ST_BR_EXE;
          default:   state_d = ST_FETCH;
        endcase
      end
      ST_R_EXE:   state_d = ST_R_WB;
      ST_ORI_EXE: state_d = ST_ORI_WB;
      ST_LW_ADDR: state_d = ST_LW_MEM;
      ST_LW_MEM:  state_d = ST_LW_WB;
      ST_SW_ADDR: state_d = ST_SW_MEM;
      default:    state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mc_ctrl_rom.sv
module mc_ctrl_rom
  import mc_ctrl_pkg::*;
(
  input  state_e state_i,
  output ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      ST_FETCH: begin
        ctrl_o.ir_wr     = 1'b1;
        ctrl_o.pc_wr     = 1'b1;
        ctrl_o.alu_b_sel = BSEL_FOUR;
        ctrl_o.alu_op    = AOP_ADD;
      end
      ST_DECODE: begin
        ctrl_o.alu_b_sel = BSEL_IMM_SH;
        ctrl_o.alu_op    = AOP_ADD;
      end
      ST_BR_EXE: begin
        ctrl_o.pc_wr_cond = 1'b1;
        ctrl_o.pc_src     = 1'b1;
        ctrl_o.alu_a_sel  = 1'b1;
        ctrl_o.alu_b_sel  = BSEL_REGB;
        ctrl_o.alu_op     = AOP_SUB;
      end
      ST_R_EXE: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = BSEL_REGB;
        ctrl_o.alu_op    = AOP_FUNC;
      end
      ST_R_WB: begin
        ctrl_o.reg_wr_req = 1'b1;
        ctrl_o.reg_dst    = 1'b1;
      end
      ST_ORI_EXE: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = BSEL_IMM;
        ctrl_o.alu_op    = AOP_OR;
        ctrl_o.ext_zero  = 1'b1;
      end
      ST_ORI_WB: ctrl_o.reg_wr_req = 1'b1;
      ST_LW_ADDR, ST_SW_ADDR: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = BSEL_IMM;
        ctrl_o.alu_op    = AOP_ADD;
      end
      ST_LW_MEM: ctrl_o.addr_sel = 1'b1;
      ST_LW_WB: begin
        ctrl_o.reg_wr_req = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
      end
      ST_SW_MEM: begin
        ctrl_o.addr_sel = 1'b1;
        ctrl_o.mem_wr   = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_wr_gate.sv
module mc_wr_gate #(
  parameter int IDX_W         = 5,
  parameter bit ZERO_REG_HARD = 1'b1
) (
  input  logic             reg_wr_req_i,
  input  logic             reg_dst_i,
  input  logic [IDX_W-1:0] rt_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             pc_wr_i,
  input  logic             pc_wr_cond_i,
  input  logic             zero_i,
  output logic             reg_wr_o,
  output logic             pc_en_o
);
  logic [IDX_W-1:0] dest_idx;
  assign dest_idx = reg_dst_i ? rd_idx_i : rt_idx_i;

  generate
    if (ZERO_REG_HARD) begin : g_zero_hard
      assign reg_wr_o = reg_wr_req_i && (dest_idx != '0);
    end else begin : g_zero_soft
      logic unused_idx;
      assign unused_idx = ^dest_idx;
      assign reg_wr_o   = reg_wr_req_i;
    end
  endgenerate

  assign pc_en_o = pc_wr_i | (pc_wr_cond_i & zero_i);
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [IDX_W-1:0]  rt_idx_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              zero_i,
  output logic [ST_W-1:0]   state_o,
  output logic              pc_wr_o,
  output logic              pc_wr_cond_o,
  output logic              pc_en_o,
  output logic              pc_src_o,
  output logic              ir_wr_o,
  output logic              mem_wr_o,
  output logic              addr_sel_o,
  output logic              reg_wr_o,
  output logic              reg_dst_o,
  output logic              mem_to_reg_o,
  output logic              alu_a_sel_o,
  output logic [BSEL_W-1:0] alu_b_sel_o,
  output logic [AOP_W-1:0]  alu_op_o,
  output logic              ext_zero_o
);
  iclass_e iclass;
  state_e  state;
  ctrl_t   ctrl;

  mc_opc_decode #(.OW(OPC_W)) u_dec (
    .opcode_i (opcode_i),
    .class_o  (iclass)
  );

  mc_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .class_i (iclass),
    .state_o (state)
  );

  mc_ctrl_rom u_rom (
    .state_i (state),
    .ctrl_o  (ctrl)
  );

  mc_wr_gate #(.IDX_W(IDX_W), .ZERO_REG_HARD(1'b1)) u_gate (
    .reg_wr_req_i (ctrl.reg_wr_req),
    .reg_dst_i    (ctrl.reg_dst),
    .rt_idx_i     (rt_idx_i),
    .rd_idx_i     (rd_idx_i),
    .pc_wr_i      (ctrl.pc_wr),
    .pc_wr_cond_i (ctrl.pc_wr_cond),
    .zero_i       (zero_i),
    .reg_wr_o     (reg_wr_o),
    .pc_en_o      (pc_en_o)
  );

  assign state_o      = state;
  assign pc_wr_o      = ctrl.pc_wr;
  assign pc_wr_cond_o = ctrl.pc_wr_cond;
  assign pc_src_o     = ctrl.pc_src;
  assign ir_wr_o      = ctrl.ir_wr;
  assign mem_wr_o     = ctrl.mem_wr;
  assign addr_sel_o   = ctrl.addr_sel;
  assign reg_dst_o    = ctrl.reg_dst;
  assign mem_to_reg_o = ctrl.mem_to_reg;
  assign alu_a_sel_o  = ctrl.alu_a_sel;
  assign alu_b_sel_o  = ctrl.alu_b_sel;
  assign alu_op_o     = ctrl.alu_op;
  assign ext_zero_o   = ctrl.ext_zero;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk
  import mc_ctrl_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OPC_W-1:0]  opcode_i,
  input logic [IDX_W-1:0]  rt_idx_i,
  input logic [IDX_W-1:0]  rd_idx_i,
  input logic              zero_i,
  input logic [ST_W-1:0]   state_o,
  input logic              pc_en_o,
  input logic              ir_wr_o,
  input logic              mem_wr_o,
  input logic              reg_wr_o,
  input logic              reg_dst_o,
  input logic              ext_zero_o
);
  logic known_opc;
  assign known_opc = (opcode_i == OPC_RTYPE) || (opcode_i == OPC_ORI) ||
                     (opcode_i == OPC_LW) || (opcode_i == OPC_SW) ||
                     (opcode_i == OPC_BEQ);

  AST_FETCH_TO_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_FETCH |=> state_o == ST_DECODE); // R2
  AST_DECODE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_DECODE |-> !(ir_wr_o || mem_wr_o || reg_wr_o || pc_en_o)); // R3
  AST_BR_PC_FOLLOWS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_BR_EXE |-> pc_en_o == zero_i); // R5
  AST_BR_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_BR_EXE |=> state_o == ST_FETCH); // R5
  AST_R_WB_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_R_WB |-> $past(state_o) == ST_R_EXE); // R6
  AST_ZEXT_ONLY_ORI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_zero_o |-> state_o == ST_ORI_EXE); // R7
  AST_LW_WB_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_LW_WB |-> $past(state_o) == ST_LW_MEM); // R8
  AST_STORE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (state_o == ST_SW_MEM) && ($past(state_o) == ST_SW_ADDR)); // R9
  AST_UNKNOWN_OPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_DECODE) && !known_opc |=> state_o == ST_FETCH); // R11
  AST_NO_REG0_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> (reg_dst_o ? rd_idx_i : rt_idx_i) != '0); // R12
  AST_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ir_wr_o, mem_wr_o, reg_wr_o})); // R13
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .opcode_i   (opcode_i),
  .rt_idx_i   (rt_idx_i),
  .rd_idx_i   (rd_idx_i),
  .zero_i     (zero_i),
  .state_o    (state_o),
  .pc_en_o    (pc_en_o),
  .ir_wr_o    (ir_wr_o),
  .mem_wr_o   (mem_wr_o),
  .reg_wr_o   (reg_wr_o),
  .reg_dst_o  (reg_dst_o),
  .ext_zero_o (ext_zero_o)
);

// File: tb/tb_mc_ctrl_fsm.sv
module tb_mc_ctrl_fsm;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] opcode_i = '0;
  logic [4:0] rt_idx_i = '0;
  logic [4:0] rd_idx_i = '0;
  logic       zero_i = 1'b0;
  logic [3:0] state_o;
  logic pc_wr_o, pc_wr_cond_o, pc_en_o, pc_src_o, ir_wr_o, mem_wr_o, addr_sel_o;
  logic reg_wr_o, reg_dst_o, mem_to_reg_o, alu_a_sel_o, ext_zero_o;
  logic [1:0] alu_b_sel_o, alu_op_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  mc_ctrl_fsm dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .opcode_i(opcode_i), .rt_idx_i(rt_idx_i),
    .rd_idx_i(rd_idx_i), .zero_i(zero_i), .state_o(state_o), .pc_wr_o(pc_wr_o),
    .pc_wr_cond_o(pc_wr_cond_o), .pc_en_o(pc_en_o), .pc_src_o(pc_src_o),
    .ir_wr_o(ir_wr_o), .mem_wr_o(mem_wr_o), .addr_sel_o(addr_sel_o),
    .reg_wr_o(reg_wr_o), .reg_dst_o(reg_dst_o), .mem_to_reg_o(mem_to_reg_o),
    .alu_a_sel_o(alu_a_sel_o), .alu_b_sel_o(alu_b_sel_o), .alu_op_o(alu_op_o),
    .ext_zero_o(ext_zero_o)
  );

  // {pc_wr, pc_wr_cond, pc_en, ir_wr, mem_wr, reg_wr, addr_sel, a_sel, b_sel, op, reg_dst, m2r, zext, pc_src}
  function automatic logic [15:0] observed();
    return {pc_wr_o, pc_wr_cond_o, pc_en_o, ir_wr_o, mem_wr_o, reg_wr_o, addr_sel_o,
            alu_a_sel_o, alu_b_sel_o, alu_op_o, reg_dst_o, mem_to_reg_o, ext_zero_o, pc_src_o};
  endfunction

  function automatic logic [15:0] expected(logic [3:0] st, logic z, logic [4:0] rd, logic [4:0] rt);
    logic pw = 0, pwc = 0, pe = 0, irw = 0, mw = 0, rw = 0, as = 0, a = 0;
    logic dst = 0, m2r = 0, zx = 0, ps = 0;
    logic [1:0] b = 0, op = 0;
    case (st)
      4'b0000: begin pw = 1; pe = 1; irw = 1; b = 2'b01; end
      4'b0001: b = 2'b11;
      4'b0010: begin pwc = 1; pe = z; ps = 1; a = 1; op = 2'b01; end
      4'b0100: begin a = 1; op = 2'b10; end
      4'b0101: begin rw = (rd != 0); dst = 1; end
      4'b0110: begin a = 1; b = 2'b10; op = 2'b11; zx = 1; end
      4'b0111: rw = (rt != 0);
      4'b1000, 4'b1011: begin a = 1; b = 2'b10; end
      4'b1001: as = 1;
      4'b1010: begin rw = (rt != 0); m2r = 1; end
      4'b1100: begin as = 1; mw = 1; end
      default: ;
    endcase
    return {pw, pwc, pe, irw, mw, rw, as, a, b, op, dst, m2r, zx, ps};
  endfunction

  function automatic string tag_of(logic [3:0] st);
    case (st)
      4'b0000: return "R2";
      4'b0001: return "R3";
      4'b0010: return "R5";
      4'b0100, 4'b0101: return "R6";
      4'b0110, 4'b0111: return "R7";
      4'b1000, 4'b1001, 4'b1010: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s state=%b actual=%h expected=%h", tag, state_o, act, exp);
    end
  endtask

  task automatic run_instr(logic [5:0] opc, logic z, logic [4:0] rd, logic [4:0] rt);
    logic [3:0] path [5];
    int len;
    bit known;
    path[0] = 4'b0000;
    path[1] = 4'b0001;
    known = 1'b1;
    case (opc)
      6'h00: begin path[2] = 4'b0100; path[3] = 4'b0101; len = 4; end
      6'h0D: begin path[2] = 4'b0110; path[3] = 4'b0111; len = 4; end
      6'h23: begin path[2] = 4'b1000; path[3] = 4'b1001; path[4] = 4'b1010; len = 5; end
      6'h2B: begin path[2] = 4'b1011; path[3] = 4'b1100; len = 4; end
      6'h04: begin path[2] = 4'b0010; len = 3; end
      default: begin len = 2; known = 1'b0; end
    endcase
    opcode_i = opc; zero_i = z; rd_idx_i = rd; rt_idx_i = rt;
    for (int i = 0; i < len; i++) begin
      #1;
      // state code per step: R10; the step after decode is the R4 dispatch
      check((i == 2) ? "R4" : "R10", {12'd0, state_o}, {12'd0, path[i]});
      check(tag_of(path[i]), observed(), expected(path[i], z, rd, rt));
      if (path[i] inside {4'b0101, 4'b0111, 4'b1010} && ((path[i] == 4'b0101) ? rd : rt) == 0)
        check("R12", {15'd0, reg_wr_o}, 16'd0);
      check("R13", {14'd0, 2'(int'(ir_wr_o) + int'(mem_wr_o) + int'(reg_wr_o))} <= 16'd1 ? 16'd0 : 16'd1, 16'd0);
      if (!known) check("R11", {13'd0, ir_wr_o && i == 1, mem_wr_o, reg_wr_o}, 16'd0);
      @(posedge clk_i);
      @(negedge clk_i);
    end
    #1;
    check(known ? "R10" : "R11", {12'd0, state_o}, 16'd0);
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    opcode_i = 6'h23;
    repeat (2) @(negedge clk_i);
    #1;
    // R1: reset holds fetch state and fetch controls
    check("R1", {12'd0, state_o}, 16'd0);
    check("R1", observed(), expected(4'b0000, 1'b0, 5'd0, 5'd0));
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int opc = 0; opc < 64; opc++)
      for (int z = 0; z < 2; z++)
        for (int d = 0; d < 4; d++) begin
          logic [4:0] rd, rt;
          case (d)
            0: begin rd = 5'd0;  rt = 5'd0;  end
            1: begin rd = 5'd0;  rt = 5'd7;  end
            2: begin rd = 5'd9;  rt = 5'd0;  end
            default: begin rd = 5'd31; rt = 5'd5; end
          endcase
          run_instr(6'(opc), z[0], rd, rt);
        end
    // reset in mid-instruction returns to fetch (R1)
    run_instr(6'h00, 1'b0, 5'd3, 5'd4);
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", {12'd0, state_o}, 16'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule